// File: doc/BRIEF.md
# Mode-Switched Vector Multiply-Accumulate Slice

This block is a compact vector multiply-accumulate datapath. It has one wide X operand (256 bits) and one narrow Z operand (64 bits). The same array of 32 byte-sized multipliers serves every operand precision. When the operands are bytes, each multiplier works on its own. When they are wider, the multipliers are ganged, so the number of products per cycle halves each time the operand width doubles. A complex product uses the cost of four real products.

Z elements are shared across lanes. Each X element is paired with a Z element chosen by rotating its index by a broadcast select. Products are summed by a post-add stage and added into sixteen accumulator lanes. A lane is 48 bits wide for modes with 16-bit or narrower operands, and 80 bits wide for 32-bit operands.

The output stage reads the accumulators combinationally. It applies an arithmetic right shift, then one of three rounding rules, then an optional symmetric saturation, and produces sixteen 32-bit results. A clear input makes an enabled cycle start a fresh sum instead of adding to the stored one.

Top module: `vmac_slice`

## Requirements
- R1: Mode 0 (byte × byte) forms 32 products. X byte e (bits 8e+7:8e) times Z byte (e+bsel) mod 8. Bytes 2j and 2j+1 are summed into lane j, for lanes 0–15.
- R2: Mode 1 (16-bit × byte) forms 16 products. X 16-bit element l (bits 16l+15:16l) times Z byte (l+bsel) mod 8 goes to lane l.
- R3: Mode 2 (16 × 16 real) forms 8 products. X 16-bit element l times Z 16-bit element (l+bsel) mod 4 goes to lane l, for l < 8. Lanes 8–15 receive nothing, so with clear set they read zero.
- R4: Mode 3 (16 × 16 complex) forms 2 complex products. A complex element c occupies bits 32c+31:32c, with the real part in the low 16 bits. X element c is multiplied by Z element (c+bsel) mod 2. The real part goes to lane 2c and the imaginary part to lane 2c+1.
- R5: Mode 4 (32 × 32 real) forms 2 products. X 32-bit element l times Z 32-bit element (l+bsel) mod 2 goes to lane l. The 80-bit lane keeps bits above bit 47.
- R6: In modes 0–3, each lane's new value is wrapped to a 48-bit signed value.
- R7: On a clock edge with en high, a lane becomes its products' sum if clr is high, and the old value plus that sum if clr is low. With en low, every lane holds.
- R8: Each lane is arithmetically shifted right by shift. rnd 0 rounds toward minus infinity. rnd 1 rounds half up. rnd 2 rounds half to even.
- R9: With sat 0, the output is the low 32 bits of the rounded value. With sat 1, the rounded value is clamped to the range ±(2^31−1).
- R10: Reset clears every lane, so all outputs read zero while shift is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Accumulate on this edge |
| clr | input | 1 | Start a new sum instead of adding |
| mode | input | 3 | Precision mode, 0–4 |
| bsel | input | 3 | Z broadcast rotation |
| x | input | 256 | Wide operand |
| z | input | 64 | Narrow operand |
| shift | input | 6 | Output right-shift amount |
| rnd | input | 2 | Rounding rule |
| sat | input | 1 | Symmetric saturation enable |
| dout | output | 512 | Sixteen 32-bit results, lane 0 in the low bits |

## Verification
The assertions assume that mode never carries codes 5–7 while en is high. The lane-width check also assumes that a 48-bit lane only sees values already reduced to 48 bits, so it is not checked across the cycle that leaves mode 4. The bench only drives the five defined mode codes. It places every mode change that leaves 80-bit lanes either on a cleared cycle or on the one directed test that deliberately observes the 48-bit wrap. Operand patterns are generated arithmetically across all modes and broadcast rotations. Hand-derived values cover the half-way cases of the rounding rules and both saturation limits.

// File: rtl/vmac_slice.sv
module vmac_slice #(
  parameter int XW   = 256,
  parameter int ZW   = 64,
  parameter int NMUL = 32,
  parameter int OW   = 32,
  parameter int SW   = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       en,
  input  logic                       clr,
  input  logic [2:0]                 mode,
  input  logic [2:0]                 bsel,
  input  logic [XW-1:0]              x,
  input  logic [ZW-1:0]              z,
  input  logic [SW-1:0]              shift,
  input  logic [1:0]                 rnd,
  input  logic                       sat,
  output logic [(NMUL/2)*OW-1:0]     dout
);
  localparam int LANES = NMUL / 2;
  localparam int L16   = NMUL / 4;
  localparam int LCPX  = NMUL / 8;
  localparam int L32   = NMUL / 16;
  localparam int AW    = 80;
  localparam int NW    = 48;
  localparam int NZ8   = ZW / 8;
  localparam int NZ16  = ZW / 16;
  localparam int NZ32  = ZW / 32;
  localparam logic signed [AW:0] MAXP = {{(AW-OW+2){1'b0}}, {(OW-1){1'b1}}};

  logic signed [AW-1:0] acc [LANES];
  logic signed [AW-1:0] sum [LANES];
  logic signed [AW-1:0] nxt [LANES];

  function automatic logic signed [AW-1:0] mul(input logic signed [AW-1:0] a,
                                               input logic signed [AW-1:0] b);
    return a * b;
  endfunction

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      sum[l] = '0;
      case (mode)
        3'd0:
          for (int k = 0; k < 2; k++)
            sum[l] = sum[l] + mul(AW'($signed(x[8*(2*l+k) +: 8])),
                                  AW'($signed(z[8*((2*l+k+int'(bsel)) % NZ8) +: 8])));
        3'd1:
          sum[l] = mul(AW'($signed(x[16*l +: 16])),
                       AW'($signed(z[8*((l+int'(bsel)) % NZ8) +: 8])));
        3'd2:
          if (l < L16)
            sum[l] = mul(AW'($signed(x[16*l +: 16])),
                         AW'($signed(z[16*((l+int'(bsel)) % NZ16) +: 16])));
        3'd3:
          if (l < 2*(LCPX/2)) begin
            if (l % 2 == 0)
              sum[l] = mul(AW'($signed(x[32*(l/2) +: 16])),
                           AW'($signed(z[32*((l/2+int'(bsel)) % NZ32) +: 16])))
                     - mul(AW'($signed(x[32*(l/2)+16 +: 16])),
                           AW'($signed(z[32*((l/2+int'(bsel)) % NZ32)+16 +: 16])));
            else
              sum[l] = mul(AW'($signed(x[32*(l/2) +: 16])),
                           AW'($signed(z[32*((l/2+int'(bsel)) % NZ32)+16 +: 16])))
                     + mul(AW'($signed(x[32*(l/2)+16 +: 16])),
                           AW'($signed(z[32*((l/2+int'(bsel)) % NZ32) +: 16])));
          end
        3'd4:
          if (l < L32)
            sum[l] = mul(AW'($signed(x[32*l +: 32])),
                         AW'($signed(z[32*((l+int'(bsel)) % NZ32) +: 32])));
        default: sum[l] = '0;
      endcase
    end
  end

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      nxt[l] = (clr ? '0 : acc[l]) + sum[l];
      if (mode != 3'd4)
        nxt[l] = {{(AW-NW){nxt[l][NW-1]}}, nxt[l][NW-1:0]};
    end
  end

  always_ff @(posedge clk) begin
    for (int l = 0; l < LANES; l++) begin
      if (!rst_n)  acc[l] <= '0;
      else if (en) acc[l] <= nxt[l];
    end
  end

  function automatic logic [OW-1:0] post(input logic signed [AW-1:0] v,
                                         input logic [SW-1:0] s,
                                         input logic [1:0] r,
                                         input logic st);
    logic signed [AW:0] w, q;
    logic [AW:0] rem, half;
    w    = {v[AW-1], v};
    q    = w >>> s;
    rem  = w - (q <<< s);
    half = (s == '0) ? '0 : ((AW+1)'(1) << (s - 1'b1));
    case (r)
      2'd1: if (s != '0 && rem >= half) q = q + 1'b1;
      2'd2: if (s != '0 && (rem > half || (rem == half && q[0]))) q = q + 1'b1;
      default: ;
    endcase
    if (st) begin
      if (q > MAXP)       q = MAXP;
      else if (q < -MAXP) q = -MAXP;
    end
    return q[OW-1:0];
  endfunction

  always_comb
    for (int l = 0; l < LANES; l++)
      dout[l*OW +: OW] = post(acc[l], shift, rnd, sat);

  // R1..R5: only the five defined precision codes are legal while accumulating
  assert_legal_mode_R1: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> mode <= 3'd4);

  assert_clear_unused_R3: assert property (@(posedge clk) disable iff (!rst_n)
    en && clr && mode == 3'd4 |=> acc[LANES-1] == '0);

  assert_narrow_lane_R6: assert property (@(posedge clk) disable iff (!rst_n)
    en && mode != 3'd4 |=> (acc[0][AW-1:NW-1] == '0 || acc[0][AW-1:NW-1] == '1));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(acc[0]) && $stable(acc[LANES-1]));

  assert_unshifted_R8: assert property (@(posedge clk) disable iff (!rst_n)
    shift == '0 && !sat |-> dout[OW-1:0] == acc[0][OW-1:0]);

  assert_symmetric_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sat |-> dout[OW-1:0] != {1'b1, {(OW-1){1'b0}}});
endmodule

// File: tb/vmac_slice_test.sv
`timescale 1ns/1ps
module vmac_slice_test;
  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, clr = 1'b0, sat = 1'b0;
  logic [2:0] mode = 3'd0, bsel = 3'd0;
  logic [255:0] x = '0;
  logic [63:0] z = '0;
  logic [5:0] shift = '0;
  logic [1:0] rnd = '0;
  logic [511:0] dout;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic signed [79:0] am [16];

  vmac_slice uut (.clk(clk), .rst_n(rst_n), .en(en), .clr(clr), .mode(mode), .bsel(bsel),
                  .x(x), .z(z), .shift(shift), .rnd(rnd), .sat(sat), .dout(dout));

  always #2.5 clk = ~clk;

  // clr[15] mode[14:12] bsel[11:9] shift[8:3] rnd[2:1] sat[0]
  localparam logic [15:0] VEC [12] = '{
    {1'b1, 3'd0, 3'd0, 6'd0,  2'd0, 1'b0},
    {1'b0, 3'd0, 3'd3, 6'd2,  2'd1, 1'b0},
    {1'b1, 3'd0, 3'd5, 6'd4,  2'd2, 1'b1},
    {1'b1, 3'd1, 3'd0, 6'd0,  2'd0, 1'b0},
    {1'b0, 3'd1, 3'd7, 6'd3,  2'd2, 1'b0},
    {1'b1, 3'd2, 3'd0, 6'd1,  2'd1, 1'b1},
    {1'b0, 3'd2, 3'd2, 6'd5,  2'd0, 1'b0},
    {1'b1, 3'd3, 3'd0, 6'd0,  2'd0, 1'b0},
    {1'b0, 3'd3, 3'd1, 6'd4,  2'd2, 1'b1},
    {1'b1, 3'd4, 3'd0, 6'd0,  2'd0, 1'b0},
    {1'b0, 3'd4, 3'd1, 6'd20, 2'd1, 1'b1},
    {1'b1, 3'd2, 3'd3, 6'd0,  2'd0, 1'b1}
  };

  function automatic logic [255:0] pat(int i, int salt);
    logic [255:0] r;
    for (int b = 0; b < 32; b++) r[8*b +: 8] = 8'((i*73 + b*29 + salt*17) ^ (b*5));
    return r;
  endfunction

  function automatic logic signed [79:0] sx(logic [31:0] v, int w);
    logic signed [79:0] r;
    r = 80'(signed'(v));
    if (w == 8)  r = 80'(signed'(v[7:0]));
    if (w == 16) r = 80'(signed'(v[15:0]));
    return r;
  endfunction

  task automatic model(bit c, int m, int b, logic [255:0] xv, logic [63:0] zv);
    logic signed [79:0] s [16];
    for (int l = 0; l < 16; l++) s[l] = '0;
    if (m == 0)
      for (int p = 0; p < 32; p++)
        s[p/2] += sx(32'(xv[8*p +: 8]), 8) * sx(32'(zv[8*((p+b)%8) +: 8]), 8);
    if (m == 1)
      for (int p = 0; p < 16; p++)
        s[p] += sx(32'(xv[16*p +: 16]), 16) * sx(32'(zv[8*((p+b)%8) +: 8]), 8);
    if (m == 2)
      for (int p = 0; p < 8; p++)
        s[p] += sx(32'(xv[16*p +: 16]), 16) * sx(32'(zv[16*((p+b)%4) +: 16]), 16);
    if (m == 3)
      for (int c2 = 0; c2 < 2; c2++) begin
        logic signed [79:0] ar, ai, br, bi;
        ar = sx(32'(xv[32*c2 +: 16]), 16);      ai = sx(32'(xv[32*c2+16 +: 16]), 16);
        br = sx(32'(zv[32*((c2+b)%2) +: 16]), 16); bi = sx(32'(zv[32*((c2+b)%2)+16 +: 16]), 16);
        s[2*c2]   = ar*br - ai*bi;
        s[2*c2+1] = ar*bi + ai*br;
      end
    if (m == 4)
      for (int p = 0; p < 2; p++)
        s[p] += sx(xv[32*p +: 32], 32) * sx(zv[32*((p+b)%2) +: 32], 32);
    for (int l = 0; l < 16; l++) begin
      am[l] = c ? s[l] : am[l] + s[l];
      if (m != 4) am[l] = 80'(signed'(am[l][47:0]));
    end
  endtask

  function automatic logic [31:0] post_m(logic signed [79:0] v, int s, int r, bit st);
    logic signed [81:0] w, q, fr, unit;
    w = 82'(v);
    q = w >>> s;
    fr = w - (q <<< s);
    unit = 82'sd1 <<< s;
    if (r == 1 && s > 0 && 2*fr >= unit) q++;
    if (r == 2 && s > 0 && (2*fr > unit || (2*fr == unit && q[0]))) q++;
    if (st && q > 82'sd2147483647)  q = 82'sd2147483647;
    if (st && q < -82'sd2147483647) q = -82'sd2147483647;
    return q[31:0];
  endfunction

  task automatic check(string tag, logic [511:0] got, logic [511:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic step(bit c, logic [2:0] m, logic [2:0] b, logic [255:0] xv, logic [63:0] zv);
    @(negedge clk);
    en = 1'b1; clr = c; mode = m; bsel = b; x = xv; z = zv;
    model(c, int'(m), int'(b), xv, zv);
    @(negedge clk);
    en = 1'b0;
  endtask

  task automatic post_set(int s, int r, bit st);
    shift = 6'(s); rnd = 2'(r); sat = st;
    #1;
  endtask

  function automatic string tag_of(logic [2:0] m);
    case (m)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      default: return "R5";
    endcase
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [511:0] e;
    for (int l = 0; l < 16; l++) am[l] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R10 reset", dout, '0);

    for (int i = 0; i < 12; i++) begin
      step(VEC[i][15], VEC[i][14:12], VEC[i][11:9], pat(i, 1), pat(i, 7)[63:0]);
      post_set(int'(VEC[i][8:3]), int'(VEC[i][2:1]), VEC[i][0]);
      for (int l = 0; l < 16; l++)
        e[32*l +: 32] = post_m(am[l], int'(VEC[i][8:3]), int'(VEC[i][2:1]), VEC[i][0]);
      check(VEC[i][15] ? tag_of(VEC[i][14:12]) : "R7 accumulate", dout, e);
    end

    // R3: unused lanes read zero after a cleared 16x16 real cycle
    check("R3 unused", {256'(dout[511:256]), 256'd0}, '0);

    // R8 rounding: lane0 = 10, 6, -10, -6 with shift 2
    step(1'b1, 3'd2, 3'd0, 256'd2, 64'd5);
    post_set(2, 0, 1'b0); check("R8 trunc 2.5", 512'(dout[31:0]), 512'd2);
    post_set(2, 1, 1'b0); check("R8 halfup 2.5", 512'(dout[31:0]), 512'd3);
    post_set(2, 2, 1'b0); check("R8 even 2.5", 512'(dout[31:0]), 512'd2);
    step(1'b1, 3'd2, 3'd0, 256'd2, 64'd3);
    post_set(2, 2, 1'b0); check("R8 even 1.5", 512'(dout[31:0]), 512'd2);
    step(1'b1, 3'd2, 3'd0, 256'hfffe, 64'd5);
    post_set(2, 0, 1'b0); check("R8 trunc -2.5", 512'(dout[31:0]), 512'hfffffffd);
    post_set(2, 1, 1'b0); check("R8 halfup -2.5", 512'(dout[31:0]), 512'hfffffffe);
    post_set(2, 2, 1'b0); check("R8 even -2.5", 512'(dout[31:0]), 512'hfffffffe);
    step(1'b1, 3'd2, 3'd0, 256'hfffe, 64'd3);
    post_set(2, 1, 1'b0); check("R8 halfup -1.5", 512'(dout[31:0]), 512'hffffffff);
    post_set(2, 2, 1'b0); check("R8 even -1.5", 512'(dout[31:0]), 512'hfffffffe);

    // R9 / R5: large 32x32 products
    step(1'b1, 3'd4, 3'd0, 256'h7fffffff, 64'h7fffffff);
    post_set(0, 0, 1'b1);  check("R9 clamp high", 512'(dout[31:0]), 512'h7fffffff);
    post_set(0, 0, 1'b0);  check("R9 wrap high", 512'(dout[31:0]), 512'h00000001);
    post_set(48, 0, 1'b0); check("R5 wide lane", 512'(dout[31:0]), 512'd16383);

    // R6: leaving 32-bit mode without clear wraps lane0 to 48 bits
    step(1'b0, 3'd2, 3'd0, 256'd0, 64'd0);
    post_set(32, 0, 1'b0); check("R6 wrap48", 512'(dout[31:0]), 512'hffffffff);

    step(1'b1, 3'd4, 3'd0, 256'h80000001, 64'h7fffffff);
    post_set(0, 0, 1'b1); check("R9 clamp low", 512'(dout[31:0]), 512'h80000001);
    post_set(0, 0, 1'b0); check("R9 wrap low", 512'(dout[31:0]), 512'hffffffff);

    // R7: en low holds lanes while inputs change
    @(negedge clk); x = pat(99, 2); z = 64'h1234_5678_9abc_def0; clr = 1'b1; mode = 3'd0;
    @(negedge clk); @(negedge clk);
    check("R7 hold", 512'(dout[31:0]), 512'hffffffff);

    // R10: reset mid-run clears lanes
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    post_set(0, 0, 1'b0);
    check("R10 reset again", dout, '0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule